// File: doc/BRIEF.md
# Two-Wire Register Write Slave

This block is the slave end of a two-wire serial bus. It lets an external master write an internal register file of up to 128 eight-bit entries. The block watches the clock and data lines and finds start and stop conditions. The first byte after a start carries a device identifier and a direction bit. When the identifier matches and the direction is write, the block takes a register address byte. It then writes the data bytes that follow, one at a time, through a single-cycle strobe.

The `auto_inc` input sets how the bytes after the address byte are read. With `auto_inc` low, every data byte needs its own register address byte first, so address and data bytes take turns until the master ends the transfer. With `auto_inc` high, one address byte is followed by a run of data bytes, and the address steps up by one after each write.

The block never drives the data line high. It only pulls it low, and only during the acknowledge clock. Both bus lines are brought into the system clock domain through a two-flop synchronizer before any edge is used.

Top module: `serial_regwr_slave`

## Requirements
- R1: A start condition (data falls while the clock is high) or a stop condition (data rises while the clock is high) returns the byte-role logic to waiting for an identifier, from any state. A partial byte cut off by either condition is discarded and produces no write.
- R2: When the first byte after a start has bits 7..1 (first bit sent is bit 7) equal to the `DEV_ID` parameter and bit 0 equal to 0 (write), the slave pulls the data line low during the 9th clock. The line stays low over that clock's whole high period.
- R3: If the identifier does not match, or bit 0 of the first byte is 1, the slave does not acknowledge it. It then acknowledges no later byte and performs no write until the next start.
- R4: `sda_pull` (1 = pull the data line low, 0 = release) is 0 in every clock period other than an acknowledge clock.
- R5: In a selected write transfer, the byte after the identifier is a register address byte. Its bits 6..0 load the address register, its bit 7 is ignored, and it is acknowledged.
- R6: Each data byte is acknowledged and produces exactly one `wr_stb` pulse, one system clock long. The pulse carries the current address register value on `wr_addr` and the byte on `wr_data`.
- R7: With `auto_inc` = 0, the byte after each data byte is again a register address byte, so address and data bytes alternate until a stop.
- R8: With `auto_inc` = 1, the address register steps by one after each data byte (127 wraps to 0), and every later byte in the transfer is a data byte.
- R9: Data bits are sampled on the rising edge of the bus clock, most significant bit first.
- R10: After reset, `sda_pull` and `wr_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| auto_inc | input | 1 | 1 = address steps after each data byte; 0 = address and data bytes alternate |
| sda_pull | output | 1 | 1 = drive the data line low; 0 = release it |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register index for the write |
| wr_data | output | 8 | Byte to write |

## Verification
Completing a data byte does two things in the same system clock: it launches the write strobe, and in auto-increment mode it also steps the address register. The strobe must carry the address as it stood before the step. This case is driven by a run of auto-increment data bytes that starts at index 126, so the step crosses the 127-to-0 wrap. The logged addresses must read 126, 127, 0 in order.

A second overlap is a repeated start or a stop that arrives while an acknowledge is still owed or only part of a byte has been received. The bench checks that no write appears and that the next first byte is taken as an identifier again.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DEVID,
        ST_REGADR,
        ST_DATA
    } role_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] bits;
    } rx_byte_t;

    typedef struct packed {
        logic              stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic id_is_write(input logic [DATA_W-1:0] b,
                                         input logic [ADDR_W-1:0] id);
        return (b[DATA_W-1:1] == id) && (b[0] == 1'b0);
    endfunction

endpackage

// File: rtl/bus_sync_edge.sv
module bus_sync_edge
    import sreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_in};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_in};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign scl_old = scl_pipe[SYNC_STAGES];
    assign sda_now = sda_pipe[SYNC_STAGES-1];
    assign sda_old = sda_pipe[SYNC_STAGES];

    always_comb begin
        ev.scl_rise = scl_now & ~scl_old;
        ev.scl_fall = ~scl_now & scl_old;
        ev.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop     = scl_now & scl_old & ~sda_old & sda_now;
        ev.sda      = sda_now;
    end

endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
    import sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_rise,
    input  logic             start_c,
    input  logic             stop_c,
    input  logic             sda_s,
    output rx_byte_t         rx,
    output logic [CNT_W-1:0] bit_cnt
);
    logic [DATA_W-2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || start_c || stop_c) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (scl_rise) begin
            if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                bit_cnt <= '0;
            end else begin
                shreg   <= {shreg[DATA_W-3:0], sda_s};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end

    always_comb begin
        rx.valid = scl_rise && !start_c && !stop_c &&
                   (bit_cnt == CNT_W'(DATA_W - 1));
        rx.bits  = {shreg, sda_s};
    end

endmodule

// File: rtl/ack_driver.sv
module ack_driver
    import sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_c,
    input  logic             stop_c,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             ack_pending,
    output logic             ack_taken,
    output logic             sda_pull
);
    assign ack_taken = scl_fall && (bit_cnt == CNT_W'(DATA_W));

    always_ff @(posedge clk) begin
        if (rst || start_c || stop_c) begin
            sda_pull <= 1'b0;
        end else if (scl_fall) begin
            sda_pull <= ack_taken && ack_pending;
        end
    end

    // R4: pull only while the frame counter sits in the acknowledge slot
    a_r4_pull_in_ack_slot: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> (bit_cnt == CNT_W'(DATA_W) || bit_cnt == '0));

    // R2: once pulled, the line stays low across the clock high phase
    a_r2_hold_low: assert property (@(posedge clk) disable iff (rst)
        (sda_pull && scl_rise) |=> sda_pull);

    // R1: bus conditions release the line
    a_r1_cond_release: assert property (@(posedge clk) disable iff (rst)
        (start_c || stop_c) |=> !sda_pull);

endmodule

// File: rtl/role_fsm.sv
module role_fsm
    import sreg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ID = 7'h3A
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_c,
    input  logic     stop_c,
    input  rx_byte_t rx,
    input  logic     auto_inc,
    input  logic     ack_taken,
    output logic     ack_pending,
    output wr_req_t  wr_q
);
    role_e             state;
    logic [ADDR_W-1:0] addr_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            addr_reg    <= '0;
            ack_pending <= 1'b0;
            wr_q        <= '0;
        end else begin
            wr_q.stb <= 1'b0;
            if (start_c) begin
                state       <= ST_DEVID;
                ack_pending <= 1'b0;
            end else if (stop_c) begin
                state       <= ST_IDLE;
                ack_pending <= 1'b0;
            end else begin
                if (ack_taken) ack_pending <= 1'b0;
                if (rx.valid) begin
                    unique case (state)
                        ST_DEVID: begin
                            if (id_is_write(rx.bits, DEV_ID)) begin
                                state       <= ST_REGADR;
                                ack_pending <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_REGADR: begin
                            addr_reg    <= rx.bits[ADDR_W-1:0];
                            ack_pending <= 1'b1;
                            state       <= ST_DATA;
                        end
                        ST_DATA: begin
                            wr_q.stb    <= 1'b1;
                            wr_q.addr   <= addr_reg;
                            wr_q.data   <= rx.bits;
                            ack_pending <= 1'b1;
                            if (auto_inc) addr_reg <= addr_reg + ADDR_W'(1);
                            else          state    <= ST_REGADR;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R6: strobe lasts a single system clock
    a_r6_stb_single: assert property (@(posedge clk) disable iff (rst)
        wr_q.stb |=> !wr_q.stb);

    // R6: a strobe only follows a byte taken in the data role
    a_r6_stb_from_data: assert property (@(posedge clk) disable iff (rst)
        wr_q.stb |-> $past(state) == ST_DATA);

    // R7: alternating mode goes back to expecting an address byte
    a_r7_alternate: assert property (@(posedge clk) disable iff (rst)
        (rx.valid && state == ST_DATA && !auto_inc && !start_c && !stop_c)
            |=> state == ST_REGADR);

    // R8: address steps by one after a data byte in auto-increment mode
    a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
        (rx.valid && state == ST_DATA && auto_inc && !start_c && !stop_c)
            |=> addr_reg == $past(addr_reg) + ADDR_W'(1));

    // R3: an unselected slave owes no acknowledge
    a_r3_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !ack_pending);

endmodule

// File: rtl/serial_regwr_slave.sv
module serial_regwr_slave
    import sreg_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'h3A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       auto_inc,
    output logic       sda_pull,
    output logic       wr_stb,
    output logic [6:0] wr_addr,
    output logic [7:0] wr_data
);
    bus_ev_t          ev;
    rx_byte_t         rx;
    wr_req_t          wr_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             ack_pending;
    logic             ack_taken;

    bus_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    rx_shifter shift_i (
        .clk      (clk),
        .rst      (rst),
        .scl_rise (ev.scl_rise),
        .start_c  (ev.start),
        .stop_c   (ev.stop),
        .sda_s    (ev.sda),
        .rx       (rx),
        .bit_cnt  (bit_cnt)
    );

    role_fsm #(.DEV_ID(DEV_ID)) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start_c     (ev.start),
        .stop_c      (ev.stop),
        .rx          (rx),
        .auto_inc    (auto_inc),
        .ack_taken   (ack_taken),
        .ack_pending (ack_pending),
        .wr_q        (wr_q)
    );

    ack_driver ack_i (
        .clk         (clk),
        .rst         (rst),
        .scl_rise    (ev.scl_rise),
        .scl_fall    (ev.scl_fall),
        .start_c     (ev.start),
        .stop_c      (ev.stop),
        .bit_cnt     (bit_cnt),
        .ack_pending (ack_pending),
        .ack_taken   (ack_taken),
        .sda_pull    (sda_pull)
    );

    assign wr_stb  = wr_q.stb;
    assign wr_addr = wr_q.addr;
    assign wr_data = wr_q.data;

endmodule

// File: tb/serial_regwr_slave_tb.sv
module serial_regwr_slave_tb_top;

    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       auto_inc = 1'b0;
    logic       sda_pull;
    logic       wr_stb;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    serial_regwr_slave dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .auto_inc (auto_inc),
        .sda_pull (sda_pull),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    int checks = 0;
    int errors = 0;
    int pull_bad = 0;
    int wr_cnt = 0;
    logic [6:0] log_a [64];
    logic [7:0] log_d [64];
    bit done = 1'b0;

    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            if (wr_cnt < 64) begin
                log_a[wr_cnt] = wr_addr;
                log_d[wr_cnt] = wr_data;
            end
            wr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;    waitq(Q);
        scl_m = 1'b1; waitq(Q);
        if (sda_pull) pull_bad++;
        waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s1, s2;
        send_bits(b, 8);
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(2);
        s1 = sda_line;
        waitq(2 * Q - 3);
        s2 = sda_line;
        waitq(1);
        scl_m = 1'b0; waitq(Q);
        acked = !s1 && !s2;
    endtask

    // {identifier byte, register address byte, data byte, ack expected, write expected}
    localparam logic [25:0] VEC [7] = '{
        {8'h74, 8'h05, 8'hA5, 1'b1, 1'b1},
        {8'h74, 8'h7F, 8'h3C, 1'b1, 1'b1},
        {8'h74, 8'h85, 8'h0F, 1'b1, 1'b1},
        {8'h76, 8'h10, 8'h55, 1'b0, 1'b0},
        {8'h75, 8'h11, 8'h66, 1'b0, 1'b0},
        {8'h74, 8'h00, 8'h80, 1'b1, 1'b1},
        {8'h74, 8'h2A, 8'h01, 1'b1, 1'b1}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic a0, a1, a2, a3, a4, a5, a6;
        int base;
        waitq(5);
        // R10: reset state
        chk(sda_pull == 1'b0, "R10", "sda_pull in reset", int'(sda_pull), 0);
        chk(wr_stb == 1'b0, "R10", "wr_stb in reset", int'(wr_stb), 0);
        rst = 1'b0;
        waitq(5);
        chk(sda_pull == 1'b0 && wr_stb == 1'b0, "R10", "outputs after reset",
            int'({sda_pull, wr_stb}), 0);

        // Table walk: single alternating transfers (R2 R3 R5 R6 R9)
        for (int v = 0; v < 7; v++) begin
            logic [7:0] idb, rab, dat;
            logic ea, ew;
            {idb, rab, dat, ea, ew} = VEC[v];
            base = wr_cnt;
            bus_start();
            send_byte(idb, a0);
            send_byte(rab, a1);
            send_byte(dat, a2);
            bus_stop();
            waitq(4);
            chk(a0 == ea, ea ? "R2" : "R3", "identifier ack", int'(a0), int'(ea));
            chk(a1 == ea && a2 == ea, "R5", "address/data ack",
                int'({a1, a2}), ea ? 3 : 0);
            chk(wr_cnt - base == int'(ew), "R6", "write count", wr_cnt - base, int'(ew));
            if (ew && wr_cnt > base) begin
                chk(log_a[base] == rab[6:0], "R5", "write address",
                    int'(log_a[base]), int'(rab[6:0]));
                chk(log_d[base] == dat, "R9", "write data msb first",
                    int'(log_d[base]), int'(dat));
            end
        end

        // R7: alternating address/data pairs in one transfer
        auto_inc = 1'b0;
        base = wr_cnt;
        bus_start();
        send_byte(8'h74, a0);
        send_byte(8'h10, a1); send_byte(8'h11, a2);
        send_byte(8'h20, a3); send_byte(8'h22, a4);
        send_byte(8'h30, a5); send_byte(8'h33, a6);
        bus_stop();
        waitq(4);
        chk(a0 && a1 && a2 && a3 && a4 && a5 && a6, "R7", "all bytes acked",
            int'({a0, a1, a2, a3, a4, a5, a6}), 7'h7F);
        chk(wr_cnt - base == 3, "R7", "alternating write count", wr_cnt - base, 3);
        if (wr_cnt - base == 3) begin
            chk(log_a[base] == 7'h10 && log_d[base] == 8'h11, "R7", "pair 1",
                int'({log_a[base], log_d[base]}), 15'h1011);
            chk(log_a[base+1] == 7'h20 && log_d[base+1] == 8'h22, "R7", "pair 2",
                int'({log_a[base+1], log_d[base+1]}), 15'h2022);
            chk(log_a[base+2] == 7'h30 && log_d[base+2] == 8'h33, "R7", "pair 3",
                int'({log_a[base+2], log_d[base+2]}), 15'h3033);
        end

        // R8: auto-increment run across the 127 -> 0 wrap
        auto_inc = 1'b1;
        base = wr_cnt;
        bus_start();
        send_byte(8'h74, a0);
        send_byte(8'h7E, a1);
        send_byte(8'hA0, a2); send_byte(8'hA1, a3); send_byte(8'hA2, a4);
        bus_stop();
        waitq(4);
        chk(a0 && a1 && a2 && a3 && a4, "R8", "auto-inc acks",
            int'({a0, a1, a2, a3, a4}), 5'h1F);
        chk(wr_cnt - base == 3, "R8", "auto-inc write count", wr_cnt - base, 3);
        if (wr_cnt - base == 3) begin
            chk(log_a[base] == 7'h7E && log_d[base] == 8'hA0, "R8", "first",
                int'({log_a[base], log_d[base]}), 15'h7EA0);
            chk(log_a[base+1] == 7'h7F && log_d[base+1] == 8'hA1, "R8", "second",
                int'({log_a[base+1], log_d[base+1]}), 15'h7FA1);
            chk(log_a[base+2] == 7'h00 && log_d[base+2] == 8'hA2, "R8", "wrapped",
                int'({log_a[base+2], log_d[base+2]}), 15'h00A2);
        end
        auto_inc = 1'b0;

        // R1: stop in the middle of a data byte discards it
        base = wr_cnt;
        bus_start();
        send_byte(8'h74, a0);
        send_byte(8'h40, a1);
        send_bits(8'hF0, 4);
        bus_stop();
        waitq(4);
        chk(wr_cnt == base, "R1", "partial byte after stop", wr_cnt - base, 0);

        // R1: repeated start returns to identifier role
        base = wr_cnt;
        bus_start();
        send_byte(8'h74, a0);
        send_byte(8'h50, a1);
        bus_start();
        send_byte(8'h74, a2);
        send_byte(8'h51, a3);
        send_byte(8'h77, a4);
        bus_stop();
        waitq(4);
        chk(a2, "R1", "identifier acked after repeated start", int'(a2), 1);
        chk(wr_cnt - base == 1, "R1", "writes after repeated start", wr_cnt - base, 1);
        if (wr_cnt - base == 1)
            chk(log_a[base] == 7'h51 && log_d[base] == 8'h77, "R1", "restart write",
                int'({log_a[base], log_d[base]}), 15'h5177);

        // R3: mismatched identifier, later bytes ignored until next start
        base = wr_cnt;
        bus_start();
        send_byte(8'h76, a0);
        send_byte(8'h74, a1);
        send_byte(8'h12, a2);
        send_byte(8'h34, a3);
        bus_start();
        send_byte(8'h74, a4);
        bus_stop();
        waitq(4);
        chk(!a0 && !a1 && !a2 && !a3, "R3", "no ack while unselected",
            int'({a0, a1, a2, a3}), 0);
        chk(wr_cnt == base, "R3", "no write while unselected", wr_cnt - base, 0);
        chk(a4, "R3", "selected again after new start", int'(a4), 1);

        // R4: line released during every non-acknowledge clock
        chk(pull_bad == 0, "R4", "pull during data clocks", pull_bad, 0);

        finish_run();
    end

endmodule